// File: doc/BRIEF.md
# Serial Divide-Ratio Loader

This block is the programming front end of a frequency synthesizer. It receives divide ratios over a three-wire serial link and holds them in two parallel registers. One register feeds the reference divider and the other feeds the feedback divider. A serial word is shifted in bit by bit on rising edges of a shift clock. The last bit shifted in is a steering bit. It selects which of the two holding registers takes the word when the commit strobe is raised.

The shift clock, serial data and commit strobe arrive from outside the system clock domain. All three are brought through one shared synchronizer bank. The block then works entirely in the system clock domain. Because the serial clock and data share the same synchronizer depth, they stay aligned. The commit strobe is treated as a level: the selected register is rewritten on every system clock cycle while the synchronized strobe is high.

Top module: `ratio_loader`

## Requirements
- R1: While reset is asserted, and immediately after it is released, both ratio outputs read zero. Asserting reset in the middle of operation clears both outputs again.
- R2: When the newest shifted bit is 1 and the commit strobe is raised, the reference ratio output takes the 14-bit data field and the feedback ratio output does not change.
- R3: When the newest shifted bit is 0 and the commit strobe is raised, the feedback ratio output takes the 14-bit data field and the reference ratio output does not change.
- R4: While the commit strobe is low, shifting any number of bits leaves both ratio outputs unchanged.
- R5: The shift register holds the last 15 bits received. The data field is the 14 bits that came before the steering bit, and the first of them is the MSB. Bits shifted in earlier than those 15 are discarded.
- R6: Only a rising edge of the shift clock moves a bit in. Changes on the serial data line while the shift clock is steady, and falling edges of the shift clock, do not alter the stored word.
- R7: A commit strobe that rises between clock edges is seen at the outputs after the third rising edge of the system clock, and not after the second. This comes from two synchronizer stages plus one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data, sampled on rising edges of ser_clk |
| commit | input | 1 | Level commit strobe, idles low |
| ref_ratio | output | 14 | Latched reference divide ratio |
| fb_ratio | output | 14 | Latched feedback divide ratio |

## Verification
The assertions assume two things about the inputs. First, serial data is stable for at least the synchronizer depth before and after each rising edge of the shift clock. Second, each level of the shift clock and of the commit strobe lasts longer than one system clock period, so no edge is lost in the synchronizers. The stimulus meets both assumptions. It changes every input only on a falling system clock edge and holds each level for four system clocks. It also keeps the commit strobe low while it is shifting, so every steering decision is made on a complete word.

// File: rtl/ratio_loader_pkg.sv
package ratio_loader_pkg;

  // Destination picked by the newest shifted bit
  typedef enum logic {
    TGT_FB  = 1'b0,
    TGT_REF = 1'b1
  } target_e;

  localparam int RATIO_W_DEF = 14;
  localparam int SYNC_DEF    = 2;
  localparam int N_TARGETS   = 2;

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int RATIO_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               din_s,
  output logic               shift_evt,
  output logic [RATIO_W:0]   sreg,
  output logic [RATIO_W-1:0] field,
  output logic               ctrl_bit
);

  localparam int SR_W = RATIO_W + 1;

  // Data field sits above the steering bit; the oldest bit lands in the MSB
  function automatic logic [RATIO_W-1:0] take_field(input logic [SR_W-1:0] w);
    return w[SR_W-1:1];
  endfunction

  function automatic logic take_ctrl(input logic [SR_W-1:0] w);
    return w[0];
  endfunction

  function automatic logic [SR_W-1:0] push_bit(input logic [SR_W-1:0] w, input logic b);
    return {w[SR_W-2:0], b};
  endfunction

  logic sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign shift_evt = sclk_s & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sreg <= '0;
    else if (shift_evt) sreg <= push_bit(sreg, din_s);
  end

  assign field    = take_field(sreg);
  assign ctrl_bit = take_ctrl(sreg);

endmodule

// File: rtl/ratio_latch.sv
module ratio_latch #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end

endmodule

// File: rtl/ratio_loader.sv
module ratio_loader
  import ratio_loader_pkg::*;
#(
  parameter int RATIO_W     = RATIO_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  input  logic               commit,
  output logic [RATIO_W-1:0] ref_ratio,
  output logic [RATIO_W-1:0] fb_ratio
);

  localparam int N_IN = 3;

  logic [N_IN-1:0]                   raw_in;
  logic [N_IN-1:0]                   syn_in;
  logic                              sclk_s;
  logic                              din_sync;
  logic                              commit_lvl;
  logic                              shift_evt;
  logic [RATIO_W:0]                  sreg;
  logic [RATIO_W-1:0]                field;
  logic                              ctrl_bit;
  logic [N_TARGETS-1:0][RATIO_W-1:0] lat_q;
  logic [N_TARGETS-1:0]              lat_wr;

  assign raw_in = {commit, ser_din, ser_clk};

  sync_bank #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .sync_out (syn_in)
  );

  assign sclk_s     = syn_in[0];
  assign din_sync   = syn_in[1];
  assign commit_lvl = syn_in[2];

  serial_shifter #(.RATIO_W(RATIO_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .din_s     (din_sync),
    .shift_evt (shift_evt),
    .sreg      (sreg),
    .field     (field),
    .ctrl_bit  (ctrl_bit)
  );

  // Index 0 drives the reference ratio, index 1 the feedback ratio
  generate
    for (genvar i = 0; i < N_TARGETS; i++) begin : g_lat
      localparam target_e MY_TGT = (i == 0) ? TGT_REF : TGT_FB;
      assign lat_wr[i] = commit_lvl && (target_e'(ctrl_bit) == MY_TGT);
      ratio_latch #(.W(RATIO_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lat_wr[i]),
        .wr_data (field),
        .q       (lat_q[i])
      );
    end
  endgenerate

  assign ref_ratio = lat_q[0];
  assign fb_ratio  = lat_q[1];

endmodule

// File: rtl/ratio_loader_chk.sv
module ratio_loader_chk #(
  parameter int RATIO_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               din_sync,
  input logic               shift_evt,
  input logic               commit_lvl,
  input logic               ctrl_bit,
  input logic [RATIO_W:0]   sreg,
  input logic [RATIO_W-1:0] field,
  input logic [RATIO_W-1:0] ref_ratio,
  input logic [RATIO_W-1:0] fb_ratio
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (ref_ratio == '0 && fb_ratio == '0));

  assert_ref_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_lvl && ctrl_bit) |=> ref_ratio == $past(field));

  assert_fb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_lvl && ctrl_bit) |=> $stable(fb_ratio));

  assert_fb_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_lvl && !ctrl_bit) |=> fb_ratio == $past(field));

  assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_lvl && !ctrl_bit) |=> $stable(ref_ratio));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_lvl |=> ($stable(ref_ratio) && $stable(fb_ratio)));

  assert_newest_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> sreg[0] == $past(din_sync));

  assert_older_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> sreg[RATIO_W:1] == $past(sreg[RATIO_W-1:0]));

  assert_no_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(sreg));

endmodule

bind ratio_loader ratio_loader_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din_sync   (din_sync),
  .shift_evt  (shift_evt),
  .commit_lvl (commit_lvl),
  .ctrl_bit   (ctrl_bit),
  .sreg       (sreg),
  .field      (field),
  .ref_ratio  (ref_ratio),
  .fb_ratio   (fb_ratio)
);

// File: tb/ratio_loader_test.sv
`timescale 1ns/1ps
module ratio_loader_test;

  localparam int W = 14;
  localparam int NV = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_din, commit;
  logic [W-1:0] ref_ratio, fb_ratio;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ratio_loader uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_din   (ser_din),
    .commit    (commit),
    .ref_ratio (ref_ratio),
    .fb_ratio  (fb_ratio)
  );

  // {word (field then steering bit), expected ref, expected fb}
  localparam logic [42:0] VEC [NV] = '{
    {14'h1234, 1'b1, 14'h1234, 14'h0000},
    {14'h2ABC, 1'b0, 14'h1234, 14'h2ABC},
    {14'h3FFF, 1'b1, 14'h3FFF, 14'h2ABC},
    {14'h0001, 1'b0, 14'h3FFF, 14'h0001},
    {14'h2000, 1'b1, 14'h2000, 14'h0001}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_word(input logic [W:0] w);
    for (int i = W; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_commit;
    commit = 1'b1;
    wait_n(4);
    commit = 1'b0;
    wait_n(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; commit = 1'b0;
    wait_n(3);
    check("R1 ref in reset", ref_ratio, '0);
    check("R1 fb in reset", fb_ratio, '0);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 ref after release", ref_ratio, '0);
    check("R1 fb after release", fb_ratio, '0);

    // R2/R3: table walk
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v][42:28]);
      pulse_commit();
      check($sformatf("R2 ref vec%0d", v), ref_ratio, VEC[v][27:14]);
      check($sformatf("R3 fb vec%0d", v), fb_ratio, VEC[v][13:0]);
    end

    // R4: shift without commit, outputs hold
    send_word({14'h0F0F, 1'b1});
    check("R4 ref held", ref_ratio, 14'h2000);
    send_word({14'h00F0, 1'b0});
    check("R4 fb held", fb_ratio, 14'h0001);

    // R5: leading excess bits fall out
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_word({14'h0123, 1'b0});
    pulse_commit();
    check("R5 fb last 15 bits", fb_ratio, 14'h0123);
    check("R5 ref untouched", ref_ratio, 14'h2000);

    // R6: data toggling without a rising shift edge
    send_word({14'h0AAA, 1'b1});
    for (int i = 0; i < 6; i++) begin
      ser_din = ~ser_din;
      wait_n(3);
    end
    pulse_commit();
    check("R6 ref ignores data wiggle", ref_ratio, 14'h0AAA);

    // R7: commit latency
    send_word({14'h1555, 1'b0});
    commit = 1'b1;
    wait_n(2);
    check("R7 fb not yet after 2 edges", fb_ratio, 14'h0123);
    wait_n(1);
    check("R7 fb updated after 3 edges", fb_ratio, 14'h1555);
    commit = 1'b0;
    wait_n(5);

    // R1: reset mid-operation
    rst_n = 1'b0;
    wait_n(2);
    check("R1 ref cleared mid-run", ref_ratio, '0);
    check("R1 fb cleared mid-run", fb_ratio, '0);
    rst_n = 1'b1;
    wait_n(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule